// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Serial Bus

This block is a serial-bus target (SMBus/I2C style, 7-bit addressing) holding a small bank of byte-wide configuration registers. It samples SCL and SDA with the system clock through a two-flop synchronizer and detects start, stop and SCL edges. It drives SDA only by enabling an open-drain pull-down. Every register is also presented in parallel, and two bits are broken out as dedicated control pins: a spread-enable bit and a 24/48 MHz select bit.

A write sends the device address with R/W=0, a start index, and a byte count X. Then come up to X data bytes, which land in consecutive registers. A read first sets the index in a write phase. It then issues a repeated start with R/W=1. The target returns the value held in its count register (the last register of the bank) and then register data from the index onward, until the host answers a byte with NACK.

States: IDLE (bus free), ADDR (shift address byte), ADDR_ACK, INDEX, INDEX_ACK, COUNT, COUNT_ACK, WDATA, WDATA_ACK, SEND (shift a byte out), HOST_ACK (sample host reply), IGNORE (wait for start or stop). Transitions:
- Start goes to ADDR from any state, and stop goes to IDLE from any state.
- A full address byte goes to ADDR_ACK on a match, otherwise to IGNORE.
- ADDR_ACK goes to INDEX for a write and to SEND (with the count byte) for a read.
- The write path runs INDEX, INDEX_ACK, COUNT, COUNT_ACK and then loops WDATA and WDATA_ACK. When the count is used up, WDATA goes to IGNORE.
- SEND goes to HOST_ACK. HOST_ACK returns to SEND on an ACK and goes to IDLE on a NACK.

Top module: `smb_cfg_target`

## Requirements
- R1: The target ACKs address byte 0xD2 (7-bit address 0x69, R/W=0) and 0xD3 (R/W=1). Any other address is NACKed, and SDA stays released until the next start or stop.
- R2: In a write, the target ACKs the index byte, the count byte and each accepted data byte. The k-th data byte (k from 0) is stored in register N+k, where N is the index.
- R3: A write accepts at most X data bytes, where X is the count byte. Any further data byte is NACKed and not stored.
- R4: The register pointer advances after every data byte, written or read, and wraps from NREGS-1 to 0. The index byte's low log2(NREGS) bits select the register, and NREGS is a power of two.
- R5: After 0xD3 the target first returns the content of the count register (index NREGS-1). It then returns registers from the pointer onward, most significant bit first. Sending the count byte does not move the pointer.
- R6: A NACK from the host ends a read. The target releases SDA, and further SCL pulses read back all ones until a new start.
- R7: A stop or a start at any point abandons the transaction. A partly received byte is never stored, and bytes already acknowledged stay written.
- R8: Reset values are 0x01 for register 0, 0x01 for register 1, NREGS for register NREGS-1, and 0x00 for all others. spread_en_o is bit 0 of register 0 (1 = spread on). sel24_o is bit 0 of register 1 (1 = 24 MHz, 0 = 48 MHz).
- R9: The SDA pull-down enable changes only while the synchronized SCL is low, except when the target releases SDA because of a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREGS*8 | All registers, register i at bits [8i+7:8i] |
| spread_en_o | output | 1 | Spread-spectrum enable (register 0 bit 0) |
| sel24_o | output | 1 | Low-speed output select, 1 = 24 MHz (register 1 bit 0) |

## Verification
The bench builds the block with its default parameters: an eight-register bank at address 0x69. With eight registers, a three-byte write starting at index 6 reaches the wrap from 7 to 0, and it also rewrites the count register that a later read returns first. Both read and write wrap, the over-count NACK, aborts by stop and by repeated start in mid-byte, and both broken-out control bits fall within a handful of short transactions.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INDEX,
        S_INDEX_ACK,
        S_COUNT,
        S_COUNT_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_SEND,
        S_HOST_ACK,
        S_IGNORE
    } smb_state_t;

    localparam int SPREAD_REG = 0;
    localparam int SPREAD_BIT = 0;
    localparam int FSEL_REG   = 1;
    localparam int FSEL_BIT   = 0;

    function automatic logic [7:0] reset_byte(input int idx, input int nregs);
        if (idx == nregs - 1)   return 8'(nregs);
        if (idx == SPREAD_REG)  return 8'(1 << SPREAD_BIT);
        if (idx == FSEL_REG)    return 8'(1 << FSEL_BIT);
        return 8'h00;
    endfunction

endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_d;
    logic          sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_d    <= scl_pipe[LAST];
            sda_d    <= sda_pipe[LAST];
        end
    end

    assign scl_s    = scl_pipe[LAST];
    assign sda_s    = sda_pipe[LAST];
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [$clog2(NREGS)-1:0] wr_idx_i,
    input  logic [7:0]               wr_data_i,
    input  logic [$clog2(NREGS)-1:0] rd_idx_i,
    output logic [7:0]               rd_data_o,
    output logic [7:0]               count_o,
    output logic [NREGS*8-1:0]       regs_o
);
    logic [7:0] mem [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= reset_byte(i, NREGS);
            end
        end else if (wr_en_i) begin
            mem[wr_idx_i] <= wr_data_i;
        end
    end

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_flat
            assign regs_o[g*8 +: 8] = mem[g];
        end
    endgenerate

    assign rd_data_o = mem[rd_idx_i];
    assign count_o   = mem[NREGS-1];

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smb_cfg_pkg::*;
#(
    parameter int         NREGS    = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sda_s,
    input  logic                     ev_rise,
    input  logic                     ev_fall,
    input  logic                     ev_start,
    input  logic                     ev_stop,
    input  logic [7:0]               rdata_i,
    input  logic [7:0]               count_i,
    output logic [$clog2(NREGS)-1:0] ptr_o,
    output logic                     wr_en_o,
    output logic [7:0]               wr_data_o,
    output logic                     sda_oe_o
);
    localparam int IDXW = $clog2(NREGS);

    smb_state_t      state, state_n;
    logic [3:0]      bitcnt, bitcnt_n;
    logic [7:0]      shreg, shreg_n;
    logic [IDXW-1:0] ptr, ptr_n;
    logic [7:0]      remain, remain_n;
    logic            is_read, is_read_n;
    logic            host_ack, host_ack_n;
    logic            byte_done;

    function automatic logic [IDXW-1:0] step(input logic [IDXW-1:0] p);
        return (p == IDXW'(NREGS - 1)) ? '0 : p + IDXW'(1);
    endfunction

    assign byte_done = ev_fall && (bitcnt == 4'd8);

    // next state and datapath
    always_comb begin
        state_n    = state;
        bitcnt_n   = bitcnt;
        shreg_n    = shreg;
        ptr_n      = ptr;
        remain_n   = remain;
        is_read_n  = is_read;
        host_ack_n = host_ack;
        wr_en_o    = 1'b0;
        if (ev_stop) begin
            state_n = S_IDLE;
        end else if (ev_start) begin
            state_n  = S_ADDR;
            bitcnt_n = '0;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: ;
                S_ADDR, S_INDEX, S_COUNT, S_WDATA: begin
                    if (ev_rise && bitcnt != 4'd8) begin
                        shreg_n  = {shreg[6:0], sda_s};
                        bitcnt_n = bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt_n = '0;
                        if (state == S_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state_n   = S_ADDR_ACK;
                                is_read_n = shreg[0];
                            end else begin
                                state_n = S_IGNORE;
                            end
                        end else if (state == S_INDEX) begin
                            ptr_n   = shreg[IDXW-1:0];
                            state_n = S_INDEX_ACK;
                        end else if (state == S_COUNT) begin
                            remain_n = shreg;
                            state_n  = S_COUNT_ACK;
                        end else if (remain != 8'd0) begin
                            wr_en_o  = 1'b1;
                            remain_n = remain - 8'd1;
                            ptr_n    = step(ptr);
                            state_n  = S_WDATA_ACK;
                        end else begin
                            state_n = S_IGNORE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (ev_fall) begin
                        bitcnt_n = '0;
                        if (is_read) begin
                            state_n = S_SEND;
                            shreg_n = count_i;
                        end else begin
                            state_n = S_INDEX;
                        end
                    end
                end
                S_INDEX_ACK: if (ev_fall) state_n = S_COUNT;
                S_COUNT_ACK: if (ev_fall) state_n = S_WDATA;
                S_WDATA_ACK: if (ev_fall) state_n = S_WDATA;
                S_SEND: begin
                    if (ev_fall) begin
                        if (bitcnt == 4'd7) begin
                            state_n = S_HOST_ACK;
                        end else begin
                            shreg_n  = {shreg[6:0], 1'b0};
                            bitcnt_n = bitcnt + 4'd1;
                        end
                    end
                end
                S_HOST_ACK: begin
                    if (ev_rise) begin
                        host_ack_n = ~sda_s;
                    end else if (ev_fall) begin
                        if (host_ack) begin
                            state_n  = S_SEND;
                            shreg_n  = rdata_i;
                            ptr_n    = step(ptr);
                            bitcnt_n = '0;
                        end else begin
                            state_n = S_IDLE;
                        end
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            remain   <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
        end else begin
            state    <= state_n;
            bitcnt   <= bitcnt_n;
            shreg    <= shreg_n;
            ptr      <= ptr_n;
            remain   <= remain_n;
            is_read  <= is_read_n;
            host_ack <= host_ack_n;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_INDEX_ACK, S_COUNT_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_SEND:                                            sda_oe_o = ~shreg[7];
            default:                                           sda_oe_o = 1'b0;
        endcase
    end

    assign ptr_o     = ptr;
    assign wr_data_o = shreg;

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter int         NREGS    = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [NREGS*8-1:0] regs_o,
    output logic               spread_en_o,
    output logic               sel24_o
);
    localparam int IDXW = $clog2(NREGS);

    logic            scl_s, sda_s;
    logic            ev_rise, ev_fall, ev_start, ev_stop;
    logic [IDXW-1:0] ptr;
    logic            wr_en;
    logic [7:0]      wr_data;
    logic [7:0]      rd_data;
    logic [7:0]      count_val;

    smb_pin_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    smb_target_fsm #(.NREGS(NREGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .rdata_i   (rd_data),
        .count_i   (count_val),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    smb_reg_bank #(.NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (ptr),
        .wr_data_i (wr_data),
        .rd_idx_i  (ptr),
        .rd_data_o (rd_data),
        .count_o   (count_val),
        .regs_o    (regs_o)
    );

    assign spread_en_o = regs_o[SPREAD_REG*8 + SPREAD_BIT];
    assign sel24_o     = regs_o[FSEL_REG*8 + FSEL_BIT];

endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk #(
    parameter int NREGS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               ev_start,
    input logic               ev_stop,
    input logic               ev_fall,
    input logic               sda_oe_o,
    input logic [NREGS*8-1:0] regs_o,
    input logic               spread_en_o,
    input logic               sel24_o
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_s || $past(ev_start || ev_stop))); // R9

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe_o); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe_o); // R7

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> sda_oe_o); // R2

    AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(ev_fall)); // R3

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (spread_en_o && sel24_o)); // R8

endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NREGS(NREGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .ev_fall     (ev_fall),
    .sda_oe_o    (sda_oe_o),
    .regs_o      (regs_o),
    .spread_en_o (spread_en_o),
    .sel24_o     (sel24_o)
);

// File: tb/sim_smb_cfg_target.sv
`timescale 1ns/1ps
module sim_smb_cfg_target;
    localparam int NREGS = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               scl = 1'b1;
    logic               sda_h = 1'b1;
    logic               sda_oe;
    logic [NREGS*8-1:0] regs;
    logic               spread_en;
    logic               sel24;
    logic               sda_line;
    logic [7:0]         exp_r [NREGS];
    int                 n_chk = 0;
    int                 n_bad = 0;
    bit                 done = 1'b0;

    assign sda_line = sda_h & ~sda_oe;

    always #2.5 clk = ~clk;

    smb_cfg_target #(.NREGS(NREGS), .DEV_ADDR(7'h69)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .regs_o      (regs),
        .spread_en_o (spread_en),
        .sel24_o     (sel24)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_clk(6);
        scl   = 1'b1; wait_clk(8);
        sda_h = 1'b0; wait_clk(8);
        scl   = 1'b0; wait_clk(6);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_clk(6);
        scl   = 1'b1; wait_clk(8);
        sda_h = 1'b1; wait_clk(8);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; wait_clk(6);
        scl = 1'b1; wait_clk(12);
        scl = 1'b0; wait_clk(6);
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; wait_clk(6);
        scl = 1'b1; wait_clk(6);
        b = sda_line; wait_clk(6);
        scl = 1'b0; wait_clk(6);
    endtask

    // sends one byte and checks the acknowledge bit (1 = ACK expected)
    task automatic tx_byte(input string req, input logic [7:0] v, input logic exp_ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        check_eq(req, $sformatf("ack after byte %02h", v), {31'd0, ~b}, {31'd0, exp_ack});
    endtask

    task automatic rx_byte(input string req, input logic [7:0] exp, input logic give_ack);
        logic b;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
        check_eq(req, "read byte", {24'd0, v}, {24'd0, exp});
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++)
            check_eq(req, $sformatf("reg%0d", i), {24'd0, regs[i*8 +: 8]}, {24'd0, exp_r[i]});
    endtask

    task automatic t_reset();
        exp_r[0] = 8'h01; exp_r[1] = 8'h01; exp_r[NREGS-1] = 8'(NREGS);
        for (int i = 2; i < NREGS - 1; i++) exp_r[i] = 8'h00;
        check_regs("R8");
        check_eq("R8", "spread_en", {31'd0, spread_en}, 32'd1);
        check_eq("R8", "sel24", {31'd0, sel24}, 32'd1);
        check_eq("R8", "sda_oe idle", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_write_basic();
        bus_start();
        tx_byte("R1", 8'hD2, 1'b1);
        tx_byte("R2", 8'h02, 1'b1);
        tx_byte("R2", 8'h03, 1'b1);
        tx_byte("R2", 8'hA1, 1'b1);
        tx_byte("R2", 8'hB2, 1'b1);
        tx_byte("R2", 8'hC3, 1'b1);
        bus_stop();
        exp_r[2] = 8'hA1; exp_r[3] = 8'hB2; exp_r[4] = 8'hC3;
        check_regs("R2");
    endtask

    task automatic t_count_limit();
        bus_start();
        tx_byte("R3", 8'hD2, 1'b1);
        tx_byte("R3", 8'h05, 1'b1);
        tx_byte("R3", 8'h01, 1'b1);
        tx_byte("R3", 8'h55, 1'b1);
        tx_byte("R3", 8'h66, 1'b0);
        bus_stop();
        exp_r[5] = 8'h55;
        check_regs("R3");
    endtask

    task automatic t_wrap_write();
        bus_start();
        tx_byte("R4", 8'hD2, 1'b1);
        tx_byte("R4", 8'h06, 1'b1);
        tx_byte("R4", 8'h03, 1'b1);
        tx_byte("R4", 8'h77, 1'b1);
        tx_byte("R4", 8'h04, 1'b1);
        tx_byte("R4", 8'h98, 1'b1);
        bus_stop();
        exp_r[6] = 8'h77; exp_r[7] = 8'h04; exp_r[0] = 8'h98;
        check_regs("R4");
        check_eq("R8", "spread_en follows reg0 bit0", {31'd0, spread_en}, 32'd0);
    endtask

    task automatic t_read();
        bus_start();
        tx_byte("R5", 8'hD2, 1'b1);
        tx_byte("R5", 8'h02, 1'b1);
        bus_start();
        tx_byte("R1", 8'hD3, 1'b1);
        rx_byte("R5", exp_r[7], 1'b1);
        rx_byte("R5", 8'hA1, 1'b1);
        rx_byte("R5", 8'hB2, 1'b1);
        rx_byte("R6", 8'hC3, 1'b0);
        rx_byte("R6", 8'hFF, 1'b0);
        bus_stop();
        check_regs("R5");
    endtask

    task automatic t_read_wrap();
        bus_start();
        tx_byte("R4", 8'hD2, 1'b1);
        tx_byte("R4", 8'h07, 1'b1);
        bus_start();
        tx_byte("R4", 8'hD3, 1'b1);
        rx_byte("R5", 8'h04, 1'b1);
        rx_byte("R4", 8'h04, 1'b1);
        rx_byte("R4", 8'h98, 1'b0);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        bus_start();
        tx_byte("R1", 8'hA4, 1'b0);
        tx_byte("R1", 8'h00, 1'b0);
        tx_byte("R1", 8'h5F, 1'b0);
        bus_stop();
        bus_start();
        tx_byte("R1", 8'hD0, 1'b0);
        bus_stop();
        check_regs("R1");
    endtask

    task automatic t_abort_stop();
        bus_start();
        tx_byte("R7", 8'hD2, 1'b1);
        tx_byte("R7", 8'h03, 1'b1);
        tx_byte("R7", 8'h02, 1'b1);
        tx_byte("R7", 8'h5A, 1'b1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        exp_r[3] = 8'h5A;
        check_regs("R7");
        check_eq("R7", "sda_oe after stop", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_abort_start();
        bus_start();
        tx_byte("R7", 8'hD2, 1'b1);
        tx_byte("R7", 8'h00, 1'b1);
        tx_byte("R7", 8'h02, 1'b1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        tx_byte("R7", 8'hD2, 1'b1);
        tx_byte("R7", 8'h01, 1'b1);
        tx_byte("R7", 8'h01, 1'b1);
        tx_byte("R7", 8'h00, 1'b1);
        bus_stop();
        exp_r[1] = 8'h00;
        check_regs("R7");
        check_eq("R8", "sel24 follows reg1 bit0", {31'd0, sel24}, 32'd0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_basic();
        t_count_limit();
        t_wrap_write();
        t_read();
        t_read_wrap();
        t_bad_addr();
        t_abort_stop();
        t_abort_start();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule